// File: doc/BRIEF.md
# MMU Alternate-Space Control Port

This block sits between the load/store unit and the address translation logic of a 32-bit processor and answers the two alternate address spaces that reach the memory management unit. One space holds a small file of control registers. The other holds flush and probe operations. A store to the flush space asks the TLB to drop one page or all of its entries. A load from the flush space returns the result of a table-walk probe, which an external walker supplies.

The register file holds a two-bit control word, a context number, a fault-status word that clears when it is read, and a fault-address word. Any change that makes existing translations stale triggers a full TLB flush. Flush requests leave the block through a valid/ready pair. A request stays on the port until the TLB accepts it. A second request that arrives before the first has been accepted is folded into a single full flush, so no invalidation is ever lost.

Load results are registered and appear one cycle after the access, marked by a read-valid strobe.

Top module: `mmu_ctrl_port`

## Requirements
- R1: A register-space access (space code 1) selects register index `acc_addr[11:8]`. A load returns that register on `rd_data` with `rd_valid` high in the cycle after the access. In every other cycle `rd_data` is zero.
- R2: Loading the fault-status register (index 3) returns its current value, and the register then reads zero. If a fault is logged in the same cycle, the logged value is kept.
- R3: A store to index 0 keeps only bit 0 (translation enable) and bit 1 (no-fault mode); all other bits read back as zero. If either bit changes, a full flush is requested in the following cycle.
- R4: A store to index 2 (context) stores the full word. A full flush is requested only when the new value differs from the old one.
- R5: Stores to index 3 and index 4 are ignored. Stores to any other index keep the written word unchanged.
- R6: A pulse on `fault_log_valid` loads `fault_log_status` into index 3 and `fault_log_addr` into index 4.
- R7: A store in the flush space (space code 2) with level `acc_addr[11:8]` = 0 requests a single-page flush. The page address is `acc_addr` with bits [11:0] cleared, and `flush_all` is low.
- R8: A flush-space store with level 1 to 4 requests a full flush. A level above 4 requests nothing.
- R9: A flush-space load (probe) with level 0 to 4 returns `probe_rdata`. A level above 4 returns zero.
- R10: `flush_valid` and its payload stay stable until `flush_ready` is high at a clock edge. A new request that arrives while one is still pending is merged into one full flush.
- R11: Accesses with space code 0 or 3 return zero on a load and change no register on a store.
- R12: After reset all registers read zero, `flush_valid` is low and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_space | input | 2 | 1 register space, 2 flush/probe space, 0 and 3 unsupported |
| acc_write | input | 1 | 1 store, 0 load |
| acc_addr | input | 32 | Access address; bits [11:8] carry the index or level |
| acc_wdata | input | 32 | Store data |
| probe_rdata | input | 32 | Result from the external table walker |
| fault_log_valid | input | 1 | Record a translation fault |
| fault_log_status | input | 32 | Fault status to record |
| fault_log_addr | input | 32 | Faulting address to record |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 32 | Load result |
| flush_valid | output | 1 | Flush request pending |
| flush_ready | input | 1 | TLB accepts the flush request |
| flush_all | output | 1 | 1 full flush, 0 single page |
| flush_page | output | 32 | Page address of a single-page flush |

## Verification
A corrupted control or context register shows up in two ways. The next load of that index returns the wrong value one cycle later. Separately, a redundant or missing full flush appears on `flush_valid` in the cycle after the store that compares against the stale value. A fault-status register that fails to clear is exposed by the second of two back-to-back loads. A pending-flush state that is lost or that never drops shows on `flush_valid` within one cycle of the `flush_ready` edge.

// File: rtl/mmu_port_pkg.sv
package mmu_port_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int IDX_LSB   = 8;
    localparam int PAGE_BITS = 12;
    localparam int MAX_LEVEL = 4;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_CTX   = 2;
    localparam int IDX_FSTAT = 3;
    localparam int IDX_FADDR = 4;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_NF_BIT = 1;

    typedef enum logic [1:0] {
        SP_NONE  = 2'd0,
        SP_REG   = 2'd1,
        SP_FLUSH = 2'd2,
        SP_RSVD  = 2'd3
    } space_e;

    typedef struct packed {
        logic             any_rd;
        logic             reg_rd;
        logic             reg_wr;
        logic             probe;
        logic             lvl_ok;
        logic             flush_pg;
        logic             flush_all;
        logic [IDX_W-1:0] idx;
    } acc_dec_t;

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        m[CTRL_EN_BIT] = 1'b1;
        m[CTRL_NF_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/mmu_acc_decode.sv
module mmu_acc_decode
    import mmu_port_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int IW      = IDX_W,
    parameter int FLD_LSB = IDX_LSB
) (
    input  logic          valid,
    input  logic [1:0]    space,
    input  logic          write,
    input  logic [AW-1:0] addr,
    output acc_dec_t      dec
);
    logic [IW-1:0] field;
    logic          in_reg;
    logic          in_flush;

    always_comb begin
        field    = addr[FLD_LSB +: IW];
        in_reg   = valid && (space_e'(space) == SP_REG);
        in_flush = valid && (space_e'(space) == SP_FLUSH);

        dec           = '0;
        dec.idx       = field;
        dec.lvl_ok    = (int'(field) <= MAX_LEVEL);
        dec.any_rd    = valid && !write;
        dec.reg_rd    = in_reg && !write;
        dec.reg_wr    = in_reg && write;
        dec.probe     = in_flush && !write;
        dec.flush_pg  = in_flush && write && (field == '0);
        dec.flush_all = in_flush && write && (field != '0) && (int'(field) <= MAX_LEVEL);
    end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
    import mmu_port_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic          log_valid,
    input  logic [DW-1:0] log_status,
    input  logic [DW-1:0] log_addr,
    output logic [DW-1:0] rdata,
    output logic          stale_req
);
    localparam int NREG = 1 << IW;

    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] cmask;

    assign cmask = DW'(ctrl_mask());

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_wr;
        logic hit_rd;
        assign hit_wr = wr_en && (int'(idx) == g);
        assign hit_rd = rd_en && (int'(idx) == g);

        if (g == IDX_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst)         regs[g] <= '0;
                else if (hit_wr) regs[g] <= wdata & cmask;
            end
        end else if (g == IDX_FSTAT) begin : g_fstat
            always_ff @(posedge clk) begin
                if (rst)            regs[g] <= '0;
                else if (log_valid) regs[g] <= log_status;
                else if (hit_rd)    regs[g] <= '0;
            end
        end else if (g == IDX_FADDR) begin : g_faddr
            always_ff @(posedge clk) begin
                if (rst)            regs[g] <= '0;
                else if (log_valid) regs[g] <= log_addr;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)         regs[g] <= '0;
                else if (hit_wr) regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata     = regs[idx];
        stale_req = 1'b0;
        if (wr_en && int'(idx) == IDX_CTRL)
            stale_req = ((wdata & cmask) != regs[IDX_CTRL]);
        else if (wr_en && int'(idx) == IDX_CTX)
            stale_req = (wdata != regs[IDX_CTX]);
    end
endmodule

// File: rtl/mmu_flush_queue.sv
module mmu_flush_queue
    import mmu_port_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_page,
    input  logic          req_all,
    input  logic [AW-1:0] req_addr,
    input  logic          ready,
    output logic          valid,
    output logic          all,
    output logic [AW-1:0] page
);
    logic pend_q, all_q;
    logic [AW-1:0] page_q;
    logic keep;
    logic new_req;

    assign keep    = pend_q && !ready;
    assign new_req = req_page || req_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            all_q  <= 1'b0;
            page_q <= '0;
        end else if (new_req) begin
            pend_q <= 1'b1;
            all_q  <= req_all || keep;
            page_q <= (req_all || keep) ? '0 : page_of(req_addr);
        end else if (!keep) begin
            pend_q <= 1'b0;
            all_q  <= 1'b0;
            page_q <= '0;
        end
    end

    assign valid = pend_q;
    assign all   = all_q;
    assign page  = page_q;
endmodule

// File: rtl/mmu_ctrl_port.sv
module mmu_ctrl_port
    import mmu_port_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [1:0]    acc_space,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] probe_rdata,
    input  logic          fault_log_valid,
    input  logic [DW-1:0] fault_log_status,
    input  logic [DW-1:0] fault_log_addr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          flush_valid,
    input  logic          flush_ready,
    output logic          flush_all,
    output logic [AW-1:0] flush_page
);
    acc_dec_t      dec;
    logic [DW-1:0] bank_rdata;
    logic          stale_req;
    logic [DW-1:0] rd_next;
    logic          rd_valid_q;
    logic [DW-1:0] rd_data_q;

    mmu_acc_decode #(.AW(AW), .IW(IW), .FLD_LSB(IDX_LSB)) u_dec (
        .valid (acc_valid),
        .space (acc_space),
        .write (acc_write),
        .addr  (acc_addr),
        .dec   (dec)
    );

    mmu_reg_bank #(.DW(DW), .IW(IW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (dec.reg_rd),
        .wr_en      (dec.reg_wr),
        .idx        (dec.idx),
        .wdata      (acc_wdata),
        .log_valid  (fault_log_valid),
        .log_status (fault_log_status),
        .log_addr   (fault_log_addr),
        .rdata      (bank_rdata),
        .stale_req  (stale_req)
    );

    mmu_flush_queue #(.AW(AW)) u_fq (
        .clk      (clk),
        .rst      (rst),
        .req_page (dec.flush_pg),
        .req_all  (dec.flush_all || stale_req),
        .req_addr (acc_addr),
        .ready    (flush_ready),
        .valid    (flush_valid),
        .all      (flush_all),
        .page     (flush_page)
    );

    always_comb begin
        if (dec.reg_rd)                    rd_next = bank_rdata;
        else if (dec.probe && dec.lvl_ok)  rd_next = probe_rdata;
        else                               rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= dec.any_rd;
            rd_data_q  <= dec.any_rd ? rd_next : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/mmu_ctrl_port_chk.sv
module mmu_ctrl_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [1:0]  acc_space,
    input logic        acc_write,
    input logic [31:0] acc_addr,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        flush_valid,
    input logic        flush_ready,
    input logic        flush_all,
    input logic [31:0] flush_page
);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        flush_valid && !flush_ready |=> flush_valid);

    a_r10_hold_all: assert property (@(posedge clk) disable iff (rst)
        flush_valid && flush_all && !flush_ready |=> flush_all);

    a_r7_page_align: assert property (@(posedge clk) disable iff (rst)
        flush_valid && !flush_all |-> flush_page[11:0] == 12'h000);

    a_r1_rd_timing: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc_valid && !acc_write));

    a_r9_probe_range: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_space == 2'd2 && acc_addr[11:8] > 4'd4
        |=> rd_data == 32'h0);

    a_r11_unsup_read: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && (acc_space == 2'd0 || acc_space == 2'd3)
        |=> rd_data == 32'h0);

    a_r8_high_level: assert property (@(posedge clk) disable iff (rst)
        !flush_valid && acc_valid && acc_write && acc_space == 2'd2 && acc_addr[11:8] > 4'd4
        |=> !flush_valid);
endmodule

bind mmu_ctrl_port mmu_ctrl_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_space   (acc_space),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .flush_valid (flush_valid),
    .flush_ready (flush_ready),
    .flush_all   (flush_all),
    .flush_page  (flush_page)
);

// File: tb/tb_mmu_ctrl_port.sv
module tb_mmu_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PROBE_VAL = 32'hCAFE_0001;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [1:0]  acc_space;
    logic        acc_write;
    logic [31:0] acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] probe_rdata;
    logic        fault_log_valid;
    logic [31:0] fault_log_status;
    logic [31:0] fault_log_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        flush_valid;
    logic        flush_ready;
    logic        flush_all;
    logic [31:0] flush_page;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_ctrl_port dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_space(acc_space),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .probe_rdata(probe_rdata), .fault_log_valid(fault_log_valid),
        .fault_log_status(fault_log_status), .fault_log_addr(fault_log_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .flush_valid(flush_valid),
        .flush_ready(flush_ready), .flush_all(flush_all), .flush_page(flush_page)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  sp;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] erd;
        logic        ef;
        logic        eall;
        logic [31:0] epage;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'd5,  2'd1, 1'b1, 32'h0000_0100, 32'hA5A5_1234, 32'h0, 1'b0, 1'b0, 32'h0},          // R5 store index 1
        '{8'd1,  2'd1, 1'b0, 32'h0000_0100, 32'h0,         32'hA5A5_1234, 1'b0, 1'b0, 32'h0},  // R1 load index 1
        '{8'd3,  2'd1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 32'h0},          // R3 ctrl change
        '{8'd3,  2'd1, 1'b0, 32'h0000_0000, 32'h0,         32'h3, 1'b0, 1'b0, 32'h0},          // R3 masked
        '{8'd3,  2'd1, 1'b1, 32'h0000_0000, 32'h0000_0007, 32'h0, 1'b0, 1'b0, 32'h0},          // R3 no change
        '{8'd4,  2'd1, 1'b1, 32'h0000_0200, 32'h0000_0042, 32'h0, 1'b1, 1'b1, 32'h0},          // R4 ctx change
        '{8'd4,  2'd1, 1'b1, 32'h0000_0200, 32'h0000_0042, 32'h0, 1'b0, 1'b0, 32'h0},          // R4 same ctx
        '{8'd4,  2'd1, 1'b0, 32'h0000_0200, 32'h0,         32'h0000_0042, 1'b0, 1'b0, 32'h0},
        '{8'd5,  2'd1, 1'b1, 32'h0000_0300, 32'h0000_DEAD, 32'h0, 1'b0, 1'b0, 32'h0},          // R5 store fstat ignored
        '{8'd5,  2'd1, 1'b0, 32'h0000_0300, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0},
        '{8'd5,  2'd1, 1'b1, 32'h0000_0400, 32'h0000_1234, 32'h0, 1'b0, 1'b0, 32'h0},          // R5 store faddr ignored
        '{8'd5,  2'd1, 1'b0, 32'h0000_0400, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0},
        '{8'd7,  2'd2, 1'b1, 32'h1234_5078, 32'h0,         32'h0, 1'b1, 1'b0, 32'h1234_5000},  // R7 page flush
        '{8'd8,  2'd2, 1'b1, 32'h0000_0300, 32'h0,         32'h0, 1'b1, 1'b1, 32'h0},          // R8 level 3
        '{8'd8,  2'd2, 1'b1, 32'h0000_0500, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0},          // R8 level 5
        '{8'd9,  2'd2, 1'b0, 32'h0000_0400, 32'h0,         PROBE_VAL, 1'b0, 1'b0, 32'h0},      // R9 probe ok
        '{8'd9,  2'd2, 1'b0, 32'h0000_0F00, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0},          // R9 probe high
        '{8'd11, 2'd0, 1'b0, 32'h0000_0100, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0},          // R11 space 0 load
        '{8'd11, 2'd3, 1'b1, 32'h0000_0100, 32'h0000_FFFF, 32'h0, 1'b0, 1'b0, 32'h0},          // R11 space 3 store
        '{8'd11, 2'd1, 1'b0, 32'h0000_0100, 32'h0,         32'hA5A5_1234, 1'b0, 1'b0, 32'h0}   // R11 index 1 intact
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] sp, input logic wr,
                         input logic [31:0] a, input logic [31:0] d);
        acc_valid = 1'b1;
        acc_space = sp;
        acc_write = wr;
        acc_addr  = a;
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_space = 2'd0; acc_write = 1'b0;
        acc_addr = '0; acc_wdata = '0; probe_rdata = PROBE_VAL;
        fault_log_valid = 1'b0; fault_log_status = '0; fault_log_addr = '0;
        flush_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk("R12 flush_valid", {31'b0, flush_valid}, 32'h0);
        chk("R12 rd_valid", {31'b0, rd_valid}, 32'h0);
        apply(2'd1, 1'b0, 32'h0000_0200, 32'h0);
        chk("R12 ctx after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            apply(VECS[i].sp, VECS[i].wr, VECS[i].addr, VECS[i].wd);
            chk({tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, !VECS[i].wr});
            chk({tag, " rd_data"}, rd_data, VECS[i].erd);
            chk({tag, " flush_valid"}, {31'b0, flush_valid}, {31'b0, VECS[i].ef});
            if (VECS[i].ef) begin
                chk({tag, " flush_all"}, {31'b0, flush_all}, {31'b0, VECS[i].eall});
                if (!VECS[i].eall) chk({tag, " flush_page"}, flush_page, VECS[i].epage);
            end
        end

        // R6 fault log, R2 clear on read and log priority
        fault_log_valid = 1'b1; fault_log_status = 32'h0000_00A1; fault_log_addr = 32'h8000_1000;
        @(negedge clk);
        fault_log_valid = 1'b0;
        apply(2'd1, 1'b0, 32'h0000_0400, 32'h0);
        chk("R6 fault addr", rd_data, 32'h8000_1000);
        fault_log_valid = 1'b1; fault_log_status = 32'h0000_00B2;
        apply(2'd1, 1'b0, 32'h0000_0300, 32'h0);
        fault_log_valid = 1'b0;
        chk("R2 first read", rd_data, 32'h0000_00A1);
        apply(2'd1, 1'b0, 32'h0000_0300, 32'h0);
        chk("R2 log wins over clear", rd_data, 32'h0000_00B2);
        apply(2'd1, 1'b0, 32'h0000_0300, 32'h0);
        chk("R2 cleared after read", rd_data, 32'h0);

        // R10 hold and merge
        flush_ready = 1'b0;
        apply(2'd2, 1'b1, 32'h0000_A0FF, 32'h0);
        chk("R10 page pending", {31'b0, flush_valid}, 32'h1);
        chk("R10 page addr", flush_page, 32'h0000_A000);
        @(negedge clk);
        chk("R10 held valid", {31'b0, flush_valid}, 32'h1);
        chk("R10 held page", flush_page, 32'h0000_A000);
        apply(2'd2, 1'b1, 32'h0000_B000, 32'h0);
        chk("R10 merged valid", {31'b0, flush_valid}, 32'h1);
        chk("R10 merged all", {31'b0, flush_all}, 32'h1);
        flush_ready = 1'b1;
        @(negedge clk);
        chk("R10 accepted", {31'b0, flush_valid}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule